// File: doc/BRIEF.md
# Bit-Addressable Dual Parallel I/O Ports

This block is a memory-mapped peripheral with two parallel ports, A and B, each eight pins wide. Every pin has an output latch bit, an input capture bit and a direction bit. A host reaches the block through a 7-bit address, two chip-select pins, an I/O-space select, and active-low read and write strobes. A local clock samples these strobes. Each port pin is modelled as three separate signals: an input, an output value and an output enable.

A host can move a whole byte to or from a port. It can also set, clear or read one pin, and in that case the address alone selects the operation. A write-only mode register holds the operating mode of port A. The mode is passed to a separate handshake block. While port A is in a strobed mode, the mode also protects the two port B pins that the handshake block uses.

Top module: `pio_dual_port`

## Requirements
- R1: The block responds only when `cs0_ni` is 0, `cs1_i` is 1 and `mem_sel_i` is 0. Otherwise writes change nothing and `data_oe_o` stays 0.
- R2: A byte write to address 0x20 loads output latch A from `data_i`. A byte write to 0x21 loads output latch B. Each latch is always visible on `pa_o` / `pb_o`.
- R3: Writes to 0x22 and 0x23 load direction registers A and B. These registers drive `pa_oe_o` / `pb_oe_o`, where 1 means the pin drives. Writing a latch bit whose pin is an input changes `pa_o`/`pb_o` but leaves the enable at 0.
- R4: An address with bits 6:5 = 00 is a bit operation:
  - bits 2:0 give the pin;
  - bit 3 gives the port (0 = A, 1 = B);
  - on a write, bit 4 gives the action (1 = set, 0 = clear).
  `data_i` is ignored, and every other latch bit is left unchanged, including the target bit when it already holds the new value.
- R5: A bit read places the selected pin value on `data_o[7]` and zeros on `data_o[6:0]`.
- R6: On a byte read of 0x20 or 0x21, each bit returns the output latch bit if that pin is an output. Otherwise it returns the pin input, captured at the leading edge of the read strobe and held while the strobe stays low.
- R7: Reads of the direction registers (0x22, 0x23), of the mode register (bit 6 set) and of any other unused address (0x24 to 0x3F) leave `data_oe_o` at 0.
- R8: A write with address bit 6 set loads the port A mode, visible on `mode_o`. It is decoded from data bits 7:5:
  - bit 5 = 0 gives 0 (basic);
  - 0b?01 gives 1 (strobed input);
  - 0b011 gives 2 (strobed output);
  - 0b111 gives 3 (strobed output, pins floating between acknowledges).
- R9: While `mode_o` is not 0, byte writes to port B leave latch B bits 7:6 unchanged. Bit set and bit clear still reach those bits.
- R10: With `rst_ni` low, the following are all 0, with no clock needed: both output latches, both direction registers, the mode and `data_oe_o`.
- R11: Each strobe passes through two synchronising flops. A write shows on the pins after the third rising clock edge following the write strobe's falling edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| mem_sel_i | input | 1 | 1 = memory space (ignored), 0 = I/O space |
| addr_i | input | 7 | Register / bit address |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Host data bus drive enable |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A pin drive enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B pin drive enables |
| mode_o | output | 2 | Port A operating mode for the handshake block |

## Verification
Most internal faults show at the ports one clock after the write that exposes them. This is because the latches and direction registers are always visible on the pin outputs and enables:
- a wrong decode makes a neighbouring bit or the other port move;
- a lost port B mask makes bits 7:6 move.

Read-path faults show only while a read strobe is held, three edges after it falls:
- a stale capture puts the wrong value on the data bus;
- a wrong readable decode drives the bus for a write-only address.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    PA_BASIC     = 2'd0,
    PA_STB_IN    = 2'd1,
    PA_STB_OUT   = 2'd2,
    PA_STB_OUT_Z = 2'd3
  } pa_mode_e;

  typedef struct packed {
    logic       bit_op;
    logic       bit_set;
    logic       port_b;
    logic [2:0] bit_idx;
    logic       byte_a;
    logic       byte_b;
    logic       dir_a;
    logic       dir_b;
    logic       mode_wr;
    logic       readable;
  } acc_t;

  function automatic pa_mode_e decode_mode(input logic [2:0] f);
    // f = data bits 7:5
    if (!f[0])      return PA_BASIC;
    else if (!f[1]) return PA_STB_IN;
    else if (!f[2]) return PA_STB_OUT;
    else            return PA_STB_OUT_Z;
  endfunction

endpackage

// File: rtl/pio_strobe_sync.sv
module pio_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic lead_o,
  output logic trail_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      last_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], strobe_ni};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign lead_o  = last_q & ~sh_q[STAGES-1];
  assign trail_o = ~last_q & sh_q[STAGES-1];
endmodule

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic          sel_i,
  output acc_t          acc_o
);
  localparam logic [AW-1:0] ADDR_BYTE_A = AW'(7'h20);
  localparam logic [AW-1:0] ADDR_BYTE_B = AW'(7'h21);
  localparam logic [AW-1:0] ADDR_DIR_A  = AW'(7'h22);
  localparam logic [AW-1:0] ADDR_DIR_B  = AW'(7'h23);

  always_comb begin
    acc_o          = '0;
    acc_o.bit_op   = sel_i && (addr_i[6:5] == 2'b00);
    acc_o.bit_set  = addr_i[4];
    acc_o.port_b   = addr_i[3];
    acc_o.bit_idx  = addr_i[2:0];
    acc_o.byte_a   = sel_i && (addr_i == ADDR_BYTE_A);
    acc_o.byte_b   = sel_i && (addr_i == ADDR_BYTE_B);
    acc_o.dir_a    = sel_i && (addr_i == ADDR_DIR_A);
    acc_o.dir_b    = sel_i && (addr_i == ADDR_DIR_B);
    acc_o.mode_wr  = sel_i && addr_i[6];
    acc_o.readable = acc_o.bit_op | acc_o.byte_a | acc_o.byte_b;
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W  = 8,
  parameter int BW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_we_i,
  input  logic [W-1:0]  byte_d_i,
  input  logic [W-1:0]  keep_i,
  input  logic          bit_we_i,
  input  logic [BW-1:0] bit_idx_i,
  input  logic          bit_set_i,
  input  logic          dir_we_i,
  input  logic          cap_i,
  input  logic [W-1:0]  pin_i,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe_o,
  output logic [W-1:0]  rd_o
);
  logic [W-1:0] out_q, dir_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      cap_q <= '0;
    end else begin
      if (byte_we_i)     out_q <= (out_q & keep_i) | (byte_d_i & ~keep_i);
      else if (bit_we_i) out_q[bit_idx_i] <= bit_set_i;
      if (dir_we_i)      dir_q <= byte_d_i;
      if (cap_i)         cap_q <= pin_i;
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  // outputs read back their latch, inputs their captured pin
  assign rd_o     = (dir_q & out_q) | (~dir_q & cap_q);
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int W           = 8,
  parameter int AW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs0_ni,
  input  logic          cs1_i,
  input  logic          mem_sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  data_o,
  output logic          data_oe_o,
  input  logic [W-1:0]  pa_i,
  output logic [W-1:0]  pa_o,
  output logic [W-1:0]  pa_oe_o,
  input  logic [W-1:0]  pb_i,
  output logic [W-1:0]  pb_o,
  output logic [W-1:0]  pb_oe_o,
  output logic [1:0]    mode_o
);
  localparam int NPORT = 2;
  localparam int BW    = $clog2(W);
  localparam logic [W-1:0] HS_MASK = {2'b11, {(W-2){1'b0}}};

  logic     sel, rd_lead, rd_trail, wr_lead, wr_trail, wr_fire, rd_act_q;
  acc_t     acc;
  pa_mode_e mode_q;
  logic [W-1:0] keep_b;
  logic [W-1:0] pin_in  [NPORT];
  logic [W-1:0] pin_out [NPORT];
  logic [W-1:0] pin_oe  [NPORT];
  logic [W-1:0] rd_val  [NPORT];

  assign sel = ~cs0_ni & cs1_i & ~mem_sel_i;

  pio_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk_i, .rst_ni, .strobe_ni(rd_ni), .lead_o(rd_lead), .trail_o(rd_trail)
  );
  pio_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i, .rst_ni, .strobe_ni(wr_ni), .lead_o(wr_lead), .trail_o(wr_trail)
  );

  pio_decode #(.AW(AW)) u_dec (.addr_i, .sel_i(sel), .acc_o(acc));

  assign wr_fire = wr_lead & sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    mode_q <= PA_BASIC;
    else if (wr_fire & acc.mode_wr) mode_q <= decode_mode(data_i[W-1:W-3]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_act_q <= 1'b0;
    else if (rd_lead)  rd_act_q <= 1'b1;
    else if (rd_trail) rd_act_q <= 1'b0;
  end

  // handshake pins of port B are protected in any strobed mode
  assign keep_b = (mode_q != PA_BASIC) ? HS_MASK : '0;

  assign pin_in[0] = pa_i;
  assign pin_in[1] = pb_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_port #(.W(W), .BW(BW)) u_port (
      .clk_i,
      .rst_ni,
      .byte_we_i(wr_fire & ((p == 0) ? acc.byte_a : acc.byte_b)),
      .byte_d_i (data_i),
      .keep_i   ((p == 0) ? '0 : keep_b),
      .bit_we_i (wr_fire & acc.bit_op & (acc.port_b == 1'(p))),
      .bit_idx_i(BW'(acc.bit_idx)),
      .bit_set_i(acc.bit_set),
      .dir_we_i (wr_fire & ((p == 0) ? acc.dir_a : acc.dir_b)),
      .cap_i    (rd_lead & sel),
      .pin_i    (pin_in[p]),
      .pin_o    (pin_out[p]),
      .pin_oe_o (pin_oe[p]),
      .rd_o     (rd_val[p])
    );
  end

  assign pa_o    = pin_out[0];
  assign pa_oe_o = pin_oe[0];
  assign pb_o    = pin_out[1];
  assign pb_oe_o = pin_oe[1];
  assign mode_o  = mode_q;

  always_comb begin
    data_o = '0;
    if (acc.bit_op)      data_o[W-1] = rd_val[acc.port_b][BW'(acc.bit_idx)];
    else if (acc.byte_a) data_o = rd_val[0];
    else if (acc.byte_b) data_o = rd_val[1];
  end

  assign data_oe_o = rd_act_q & acc.readable;
endmodule

// File: rtl/pio_dual_port_chk.sv
module pio_dual_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs0_ni,
  input logic       cs1_i,
  input logic       mem_sel_i,
  input logic [6:0] addr_i,
  input logic       wr_fire,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic [7:0] pa_o,
  input logic [7:0] pa_oe_o,
  input logic [7:0] pb_o,
  input logic [1:0] mode_o
);
  // R10
  rst_bus_float_chk: assert property (@(posedge clk_i) !rst_ni |-> !data_oe_o);

  // R1
  desel_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs0_ni || !cs1_i || mem_sel_i) |-> !data_oe_o);

  // R7
  write_only_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (addr_i[6:5] == 2'b00 || addr_i == 7'h20 || addr_i == 7'h21));

  // R5
  bit_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && addr_i[6:5] == 2'b00) |-> (data_o[6:0] == 7'd0));

  // R4
  bit_set_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && addr_i[6:5] == 2'b00 && addr_i[4] && !addr_i[3])
    |=> pa_o == ($past(pa_o) | (8'd1 << $past(addr_i[2:0]))));

  // R3
  dir_a_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_fire && addr_i == 7'h22) |=> $stable(pa_oe_o));

  // R9
  hs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && addr_i == 7'h21 && mode_o != 2'd0)
    |=> pb_o[7:6] == $past(pb_o[7:6]));
endmodule

bind pio_dual_port pio_dual_port_chk u_chk (
  .clk_i, .rst_ni, .cs0_ni, .cs1_i, .mem_sel_i, .addr_i,
  .wr_fire, .data_o, .data_oe_o, .pa_o, .pa_oe_o, .pb_o, .mode_o
);

// File: tb/sim_pio_dual_port.sv
module sim_pio_dual_port;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs0_ni = 1'b0, cs1_i = 1'b1, mem_sel_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0] data_i = '0, pa_i = '0, pb_i = '0;
  logic [7:0] data_o, pa_o, pa_oe_o, pb_o, pb_oe_o;
  logic data_oe_o;
  logic [1:0] mode_o;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rd_d;
  logic rd_oe;

  always #5 clk = ~clk;

  pio_dual_port u0 (
    .clk_i(clk), .rst_ni, .cs0_ni, .cs1_i, .mem_sel_i, .addr_i, .rd_ni, .wr_ni,
    .data_i, .data_o, .data_oe_o, .pa_i, .pa_o, .pa_oe_o, .pb_i, .pb_o, .pb_oe_o, .mode_o
  );

  typedef struct packed {
    logic       wr;
    logic [6:0] a;
    logic [7:0] d;
    logic [7:0] pa;
    logic [7:0] pb;
    logic [7:0] exp_d;
    logic       exp_oe;
    logic [7:0] exp_pa;
    logic [7:0] exp_pb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'h20, 8'hA5, 8'h00, 8'h00, 8'h00, 1'b0, 8'hA5, 8'h00, 4'd2},  // R2
    '{1'b1, 7'h21, 8'hFC, 8'h00, 8'h00, 8'h00, 1'b0, 8'hA5, 8'hFC, 4'd2},  // R2
    '{1'b0, 7'h20, 8'h00, 8'h0F, 8'h00, 8'h0F, 1'b1, 8'hA5, 8'hFC, 4'd6},  // R6
    '{1'b0, 7'h21, 8'h00, 8'h00, 8'h96, 8'h96, 1'b1, 8'hA5, 8'hFC, 4'd6},  // R6
    '{1'b1, 7'h22, 8'hF0, 8'h00, 8'h00, 8'h00, 1'b0, 8'hA5, 8'hFC, 4'd3},  // R3
    '{1'b0, 7'h20, 8'h00, 8'h0F, 8'h00, 8'hAF, 1'b1, 8'hA5, 8'hFC, 4'd6},  // R6
    '{1'b0, 7'h22, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hA5, 8'hFC, 4'd7},  // R7
    '{1'b0, 7'h23, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hA5, 8'hFC, 4'd7},  // R7
    '{1'b0, 7'h30, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hA5, 8'hFC, 4'd7},  // R7
    '{1'b1, 7'h13, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hAD, 8'hFC, 4'd4},  // R4
    '{1'b1, 7'h0A, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 8'hAD, 8'hF8, 4'd4},  // R4
    '{1'b1, 7'h17, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hAD, 8'hF8, 4'd4},  // R4
    '{1'b0, 7'h00, 8'h00, 8'h01, 8'h00, 8'h80, 1'b1, 8'hAD, 8'hF8, 4'd5},  // R5
    '{1'b0, 7'h17, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1, 8'hAD, 8'hF8, 4'd5},  // R5
    '{1'b0, 7'h0E, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 8'hAD, 8'hF8, 4'd5},  // R5
    '{1'b0, 7'h0E, 8'h00, 8'h00, 8'h40, 8'h80, 1'b1, 8'hAD, 8'hF8, 4'd5},  // R5
    '{1'b1, 7'h40, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 8'hAD, 8'hF8, 4'd8},  // R8
    '{1'b1, 7'h21, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hAD, 8'hC0, 4'd9},  // R9
    '{1'b1, 7'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hAD, 8'h40, 4'd9},  // R9
    '{1'b1, 7'h40, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hAD, 8'h40, 4'd8},  // R8
    '{1'b1, 7'h21, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 8'hAD, 8'h00, 4'd9}   // R9
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; data_i = d; wr_ni = 1'b0;
    repeat (4) @(negedge clk);
    wr_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_rd(input logic [6:0] a);
    @(negedge clk);
    addr_i = a; rd_ni = 1'b0;
    repeat (4) @(negedge clk);
    rd_d = data_o; rd_oe = data_oe_o;
    rd_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "pa_o", pa_o, 8'h00);
    chk("R10", "pb_oe_o", pb_oe_o, 8'h00);
    chk("R10", "mode_o", {6'd0, mode_o}, 8'h00);
    chk("R10", "data_oe_o", {7'd0, data_oe_o}, 8'h00);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      pa_i = VECS[i].pa; pb_i = VECS[i].pb;
      if (VECS[i].wr) do_wr(VECS[i].a, VECS[i].d);
      else begin
        do_rd(VECS[i].a);
        chk(tag, "read oe", {7'd0, rd_oe}, {7'd0, VECS[i].exp_oe});
        if (VECS[i].exp_oe) chk(tag, "read data", rd_d, VECS[i].exp_d);
      end
      chk(tag, "pa_o", pa_o, VECS[i].exp_pa);
      chk(tag, "pb_o", pb_o, VECS[i].exp_pb);
    end

    // R3 enables follow direction registers
    chk("R3", "pa_oe_o", pa_oe_o, 8'hF0);
    do_wr(7'h23, 8'h0F);
    chk("R3", "pb_oe_o", pb_oe_o, 8'h0F);

    // R11 write latency
    @(negedge clk);
    addr_i = 7'h20; data_i = 8'h3C; wr_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "pa_o before third edge", pa_o, 8'hAD);
    @(negedge clk);
    chk("R11", "pa_o after third edge", pa_o, 8'h3C);
    repeat (2) @(negedge clk);
    wr_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 deselected accesses
    cs0_ni = 1'b1; do_wr(7'h20, 8'hFF);
    chk("R1", "pa_o cs0 high", pa_o, 8'h3C);
    cs0_ni = 1'b0; mem_sel_i = 1'b1; do_wr(7'h21, 8'hFF);
    chk("R1", "pb_o memory space", pb_o, 8'h00);
    mem_sel_i = 1'b0; cs1_i = 1'b0; do_rd(7'h20);
    chk("R1", "oe cs1 low", {7'd0, rd_oe}, 8'h00);
    cs1_i = 1'b1;

    // R6 input held through the read
    do_wr(7'h22, 8'h00);
    @(negedge clk);
    pa_i = 8'h5A; addr_i = 7'h20; rd_ni = 1'b0;
    repeat (4) @(negedge clk);
    pa_i = 8'hFF;
    repeat (2) @(negedge clk);
    chk("R6", "held capture", data_o, 8'h5A);
    rd_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R8 mode encodings
    do_wr(7'h40, 8'h60); chk("R8", "mode 0x60", {6'd0, mode_o}, 8'h02);
    do_wr(7'h7F, 8'hE0); chk("R8", "mode 0xE0", {6'd0, mode_o}, 8'h03);
    do_wr(7'h40, 8'hA0); chk("R8", "mode 0xA0", {6'd0, mode_o}, 8'h01);
    do_wr(7'h55, 8'hDF); chk("R8", "mode 0xDF", {6'd0, mode_o}, 8'h00);

    // R10 reset during an active read
    do_wr(7'h40, 8'h20);
    @(negedge clk);
    addr_i = 7'h21; rd_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "oe before reset", {7'd0, data_oe_o}, 8'h01);
    rst_ni = 1'b0;
    #1;
    chk("R10", "oe in reset", {7'd0, data_oe_o}, 8'h00);
    chk("R10", "pa_o in reset", pa_o, 8'h00);
    chk("R10", "pb_oe_o in reset", pb_oe_o, 8'h00);
    chk("R10", "mode in reset", {6'd0, mode_o}, 8'h00);
    rd_ni = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule